// File: doc/BRIEF.md
# Frame-Buffer Pixel Unpacker

This block sits between a frame-buffer fetch engine and a palette or colour stage. It takes 32-bit words on a valid/ready input, splits each into pixels according to a selected colour depth, and emits one pixel per cycle on a valid/ready output. Low depths yield a palette index. High depths yield a direct 24-bit colour value as red, green and blue bytes.

Control inputs choose the depth, a red/blue swap, a byte swap of the word and a reversal of sub-byte pixel order. A 2-bit board-level select remaps the plain 16-bit depth between three layouts. All controls are captured together with the word they apply to. A purely combinational helper converts a line length in pixels into a line length in bytes for the current depth, so the fetch side can size its bursts.

Top module: `pix_unpack`

## Requirements
- R1: After reset `pix_valid_o` is 0 and `word_ready_o` is 1.
- R2: A word is accepted (valid and ready both high) only when every pixel of the previous word has been emitted. While `pix_valid_o` is high, `word_ready_o` is 0. A stalled pixel (`pix_ready_i` low) holds its value.
- R3: Depth codes are 0=1 bpp, 1=2 bpp, 2=4 bpp and 3=8 bpp, giving 32, 16, 8 and 4 pixels per word. These depths output `pix_is_idx_o`=1 with the index in `pix_o[7:0]` and all upper bits zero.
- R4: With neither order control set, pixel n of a word comes from bits starting at n times the depth, so the first pixel is at the least significant end.
- R5: With `pix_rev_i`=1 and `byte_rev_i`=0, sub-byte pixels (1, 2 and 4 bpp) are taken from the most significant end of each byte first, and bytes are still taken low first. At 8 bpp and above the bit has no effect.
- R6: `byte_rev_i`=1 reverses the four bytes of the word before unpacking. When both order bits are set, only the byte reversal applies.
- R7: Depth code 5 gives one pixel per word. Red is bits 7:0, green is bits 15:8 and blue is bits 23:16. Bits 31:24 are ignored.
- R8: Depth code 4 gives two 16-bit pixels per word. With select value 1 the layout is 5551: red is bits 4:0, green is bits 9:5, blue is bits 14:10, and bit 15 is ignored. With select value 3 the layout is 565 with red and blue always swapped. With select value 0 or 2 the layout is 565 and honours `bgr_i`.
- R9: The 565 layout, used by depth code 6 and by depth code 4 with select 0, 2 or 3, has red in bits 4:0, green in bits 10:5 and blue in bits 15:11. 5-bit channels are shifted left by 3 and the 6-bit channel by 2, with zero fill.
- R10: Depth code 7 gives two pixels per word from 16-bit slots. Red is bits 3:0, green is bits 7:4 and blue is bits 11:8, each shifted left by 4.
- R11: Direct pixels appear as `pix_o` = {red, green, blue} with `pix_is_idx_o`=0. When `bgr_i` is 1, red and blue swap places.
- R12: `line_bytes_o` is the floor of pixels/8, /4 or /2 for codes 0, 1 and 2. It equals the pixel count for code 3, is the count times 2 for codes 4, 6 and 7, and is the count times 4 for code 5.
- R13: Depth, swap, order and select inputs are sampled when a word is accepted. Changing them afterwards does not alter the pixels of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Depth code |
| bgr_i | input | 1 | Swap red and blue of direct pixels |
| byte_rev_i | input | 1 | Reverse byte order of the word |
| pix_rev_i | input | 1 | Reverse sub-byte pixel order |
| fmt_sel_i | input | 2 | Layout select for depth code 4 |
| line_pix_i | input | LINE_W | Pixels per line |
| line_bytes_o | output | LINE_W+2 | Bytes per line for mode_i |
| word_valid_i | input | 1 | Input word valid |
| word_i | input | 32 | Input word |
| word_ready_o | output | 1 | Input word can be accepted |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_ready_i | input | 1 | Output pixel taken |
| pix_is_idx_o | output | 1 | Pixel is a palette index |
| pix_o | output | 24 | Index or {red, green, blue} |

## Verification
The embedded properties check on every cycle that no word enters while pixels are pending, that a stalled pixel and its captured controls stay put, that the pixel counter stays within the word, that index pixels carry zero upper bits and that 16-bit line lengths are even. The bit positions of each pixel under every depth, order, swap and select combination can only be shown by the bench. It sweeps every such combination over several word patterns, alters the controls right after each word is taken, and compares every pixel and line length with arithmetic expectations.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  typedef enum logic [2:0] {
    D_1   = 3'd0,
    D_2   = 3'd1,
    D_4   = 3'd2,
    D_8   = 3'd3,
    D_16  = 3'd4,
    D_24  = 3'd5,
    D_565 = 3'd6,
    D_12  = 3'd7
  } depth_e;

  typedef struct packed {
    depth_e     mode;
    logic       bgr;
    logic       pix_rev;
    logic [1:0] fmt;
  } cfg_t;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 5;

  function automatic logic [IDX_W-1:0] last_idx(depth_e m);
    case (m)
      D_1:     return 5'd31;
      D_2:     return 5'd15;
      D_4:     return 5'd7;
      D_8:     return 5'd3;
      D_24:    return 5'd0;
      default: return 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/pix_line_size.sv
module pix_line_size
  import pix_unpack_pkg::*;
#(
  parameter int unsigned LINE_W = 11
) (
  input  depth_e            mode_i,
  input  logic [LINE_W-1:0] pix_i,
  output logic [LINE_W+1:0] bytes_o
);
  logic [LINE_W+1:0] ext;
  assign ext = {2'b00, pix_i};

  always_comb begin
    case (mode_i)
      D_1:     bytes_o = ext >> 3;
      D_2:     bytes_o = ext >> 2;
      D_4:     bytes_o = ext >> 1;
      D_8:     bytes_o = ext;
      D_24:    bytes_o = ext << 2;
      default: bytes_o = ext << 1;
    endcase
  end
endmodule

// File: rtl/pix_word_buf.sv
module pix_word_buf
  import pix_unpack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              byte_rev_i,
  input  cfg_t              cfg_i,
  output logic              word_ready_o,
  input  logic              pix_ready_i,
  output logic              pix_valid_o,
  output logic [WORD_W-1:0] word_o,
  output cfg_t              cfg_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned NB = WORD_W / 8;

  logic [WORD_W-1:0] swapped;
  logic              full_q;
  logic [WORD_W-1:0] word_q;
  cfg_t              cfg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              take_word, take_pix, at_last;

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign swapped[b*8 +: 8] = word_i[(NB-1-b)*8 +: 8];
  end

  assign word_ready_o = !full_q;
  assign take_word    = word_valid_i && !full_q;
  assign take_pix     = full_q && pix_ready_i;
  assign at_last      = (idx_q == last_idx(cfg_q.mode));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
      cfg_q  <= '0;
      idx_q  <= '0;
    end else if (take_word) begin
      full_q <= 1'b1;
      word_q <= byte_rev_i ? swapped : word_i;
      cfg_q  <= cfg_i;
      idx_q  <= '0;
    end else if (take_pix) begin
      if (at_last) begin
        full_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign pix_valid_o = full_q;
  assign word_o      = word_q;
  assign cfg_o       = cfg_q;
  assign idx_o       = idx_q;

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && word_ready_o |=> pix_valid_o && !word_ready_o);
  a_r2_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> pix_valid_o && $stable(word_q) && $stable(idx_q));
  a_r13_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |=> $stable(cfg_q));
  a_r3_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> idx_q <= last_idx(cfg_q.mode));
endmodule

// File: rtl/pix_decode.sv
module pix_decode
  import pix_unpack_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  cfg_t              cfg_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [23:0]       pix_o,
  output logic              is_idx_o
);
  logic [4:0]  off, off_r;
  logic [2:0]  rev_mask;
  logic [23:0] raw;
  logic [7:0]  r, g, b;
  logic        swap;

  always_comb begin
    rev_mask = 3'd0;
    case (cfg_i.mode)
      D_1:     begin off = idx_i;                rev_mask = 3'd7; end
      D_2:     begin off = {idx_i[3:0], 1'b0};   rev_mask = 3'd6; end
      D_4:     begin off = {idx_i[2:0], 2'b00};  rev_mask = 3'd4; end
      D_8:     off = {idx_i[1:0], 3'b000};
      D_24:    off = 5'd0;
      default: off = {idx_i[0], 4'b0000};
    endcase
    if (!cfg_i.pix_rev) rev_mask = 3'd0;
    off_r = {off[4:3], off[2:0] ^ rev_mask};
  end

  assign raw = 24'(word_i >> off_r);

  always_comb begin
    swap = cfg_i.bgr;
    r = 8'd0; g = 8'd0; b = 8'd0;
    case (cfg_i.mode)
      D_24: begin r = raw[7:0]; g = raw[15:8]; b = raw[23:16]; end
      D_12: begin r = {raw[3:0], 4'd0}; g = {raw[7:4], 4'd0}; b = {raw[11:8], 4'd0}; end
      D_16: begin
        if (cfg_i.fmt == 2'd1) begin
          r = {raw[4:0], 3'd0}; g = {raw[9:5], 3'd0}; b = {raw[14:10], 3'd0};
        end else begin
          r = {raw[4:0], 3'd0}; g = {raw[10:5], 2'd0}; b = {raw[15:11], 3'd0};
          if (cfg_i.fmt == 2'd3) swap = 1'b1;
        end
      end
      default: begin r = {raw[4:0], 3'd0}; g = {raw[10:5], 2'd0}; b = {raw[15:11], 3'd0}; end
    endcase
  end

  always_comb begin
    case (cfg_i.mode)
      D_1:     begin is_idx_o = 1'b1; pix_o = {16'd0, 7'd0, raw[0]};   end
      D_2:     begin is_idx_o = 1'b1; pix_o = {16'd0, 6'd0, raw[1:0]}; end
      D_4:     begin is_idx_o = 1'b1; pix_o = {16'd0, 4'd0, raw[3:0]}; end
      D_8:     begin is_idx_o = 1'b1; pix_o = {16'd0, raw[7:0]};       end
      default: begin is_idx_o = 1'b0; pix_o = swap ? {b, g, r} : {r, g, b}; end
    endcase
  end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              bgr_i,
  input  logic              byte_rev_i,
  input  logic              pix_rev_i,
  input  logic [1:0]        fmt_sel_i,
  input  logic [LINE_W-1:0] line_pix_i,
  output logic [LINE_W+1:0] line_bytes_o,
  input  logic              word_valid_i,
  input  logic [31:0]       word_i,
  output logic              word_ready_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output logic              pix_is_idx_o,
  output logic [23:0]       pix_o
);
  cfg_t              cfg_in, cfg_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;

  // byte reversal wins over pixel reversal
  assign cfg_in = '{mode: depth_e'(mode_i), bgr: bgr_i,
                    pix_rev: pix_rev_i & ~byte_rev_i, fmt: fmt_sel_i};

  pix_word_buf i_buf (
    .clk_i, .rst_ni,
    .word_valid_i, .word_i, .byte_rev_i,
    .cfg_i(cfg_in),
    .word_ready_o, .pix_ready_i, .pix_valid_o,
    .word_o(word_q), .cfg_o(cfg_q), .idx_o(idx_q)
  );

  pix_decode i_dec (
    .word_i(word_q), .cfg_i(cfg_q), .idx_i(idx_q),
    .pix_o, .is_idx_o(pix_is_idx_o)
  );

  pix_line_size #(.LINE_W(LINE_W)) i_line (
    .mode_i(depth_e'(mode_i)), .pix_i(line_pix_i), .bytes_o(line_bytes_o)
  );

  a_r3_idx_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && pix_is_idx_o |-> pix_o[23:8] == 16'd0);
  a_r12_even_16b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4 || mode_i == 3'd6 || mode_i == 3'd7) |-> !line_bytes_o[0]);
  a_r1_ready_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> word_ready_o);
endmodule

// File: tb/test_pix_unpack.sv
module test_pix_unpack;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = '0;
  logic          bgr = 1'b0, brev = 1'b0, prev = 1'b0;
  logic [1:0]    fmt = '0;
  logic [LW-1:0] lpix = '0;
  logic [LW+1:0] lbytes;
  logic          wvalid = 1'b0;
  logic [31:0]   wdata = '0;
  logic          wready, pvalid, pready, pidx;
  logic [23:0]   pdata;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  pix_unpack #(.LINE_W(LW)) i_pix_unpack (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .bgr_i(bgr), .byte_rev_i(brev),
    .pix_rev_i(prev), .fmt_sel_i(fmt), .line_pix_i(lpix), .line_bytes_o(lbytes),
    .word_valid_i(wvalid), .word_i(wdata), .word_ready_o(wready),
    .pix_valid_o(pvalid), .pix_ready_i(pready), .pix_is_idx_o(pidx), .pix_o(pdata)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int depth_bits(int m);
    case (m)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      5: return 32;
      default: return 16;
    endcase
  endfunction

  // returns {is_idx, pixel}
  function automatic logic [24:0] model(logic [31:0] w, int m, bit bg, bit br,
                                        bit pr, int fs, int n);
    int bpp, pos, bitp;
    logic [31:0] ww;
    longint unsigned v;
    int rr, gg, bb;
    bit sw;
    bpp = depth_bits(m);
    ww = br ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    if (bpp < 8) begin
      pos = n % (8 / bpp);
      if (pr && !br) pos = 8 / bpp - 1 - pos;
      bitp = (n / (8 / bpp)) * 8 + pos * bpp;
    end else bitp = n * bpp;
    v = ({32'd0, ww} >> bitp) % (64'd1 << bpp);
    if (m < 4) return {1'b1, 16'd0, v[7:0]};
    sw = bg;
    if (m == 5) begin
      rr = int'(v % 256); gg = int'((v / 256) % 256); bb = int'((v / 65536) % 256);
    end else if (m == 7) begin
      rr = int'(v % 16) * 16; gg = int'((v / 16) % 16) * 16; bb = int'((v / 256) % 16) * 16;
    end else if (m == 4 && fs == 1) begin
      rr = int'(v % 32) * 8; gg = int'((v / 32) % 32) * 8; bb = int'((v / 1024) % 32) * 8;
    end else begin
      rr = int'(v % 32) * 8; gg = int'((v / 32) % 64) * 4; bb = int'((v / 2048) % 32) * 8;
      if (m == 4 && fs == 3) sw = 1'b1;
    end
    if (sw) return {1'b0, 8'(bb), 8'(gg), 8'(rr)};
    return {1'b0, 8'(rr), 8'(gg), 8'(bb)};
  endfunction

  function automatic string req_of(int m, bit br, bit pr, bit bg);
    if (br) return "R6";
    if (pr && m < 3) return "R5";
    case (m)
      5: return "R7";
      4: return "R8";
      6: return "R9";
      7: return "R10";
      default: return bg ? "R11" : "R4";
    endcase
  endfunction

  task automatic run_word(logic [31:0] w, int m, bit bg, bit br, bit pr, int fs, bit stall);
    logic [24:0] e;
    int ppw;
    string rq;
    ppw = 32 / depth_bits(m);
    rq = req_of(m, br, pr, bg);
    @(negedge clk);
    mode = 3'(m); bgr = bg; brev = br; prev = pr; fmt = 2'(fs);
    wdata = w; wvalid = 1'b1; pready = 1'b1;
    @(negedge clk);
    wvalid = 1'b0;
    // R13: scramble controls after capture
    mode = ~mode; bgr = ~bgr; brev = ~brev; prev = ~prev; fmt = ~fmt;
    for (int n = 0; n < ppw; n++) begin
      e = model(w, m, bg, br, pr, fs, n);
      chk(pvalid && pdata == e[23:0] && pidx == e[24], rq,
          {pvalid, pidx, pdata}, {1'b1, e});
      chk(!wready, "R2", wready, 0);
      if (stall && n == 1) begin
        pready = 1'b0;
        @(negedge clk);
        chk(pvalid && pdata == e[23:0], "R2", pdata, e[23:0]);
        pready = 1'b1;
      end
      if (n < ppw - 1) @(negedge clk);
    end
    @(posedge clk);
  endtask

  initial begin
    logic [31:0] pats [3];
    longint exp_b;
    pats[0] = 32'h8C3A_F15B;
    pats[1] = 32'h0123_4567;
    pats[2] = 32'hE71D_96C2;
    pready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pvalid && wready, "R1", {pvalid, wready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pvalid && wready, "R1", {pvalid, wready}, 2'b01);

    for (int m = 0; m < 8; m++)
      for (int f = 0; f < 4; f++) begin
        if (m != 4 && f != 0) continue;
        for (int c = 0; c < 8; c++)
          for (int p = 0; p < 3; p++)
            run_word(pats[p], m, c[0], c[1], c[2], f, (p == 1));
      end

    @(negedge clk);
    chk(!pvalid && wready, "R2", {pvalid, wready}, 2'b01);

    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 5; k++) begin
        lpix = LW'((k * 417 + 3) % 2048);
        mode = 3'(m);
        #1;
        exp_b = (longint'(lpix) * depth_bits(m)) / 8;
        chk(longint'(lbytes) == exp_b, "R12", lbytes, exp_b);
      end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule